// File: doc/BRIEF.md
# Rotating multi-buffer packet FIFO

This block sits on the receive path of a bulk data endpoint. A packet producer on the bus side writes a word stream into it, and a consumer on the local interface side reads the same stream back out. Inside, the storage is split into two, three or four equal packet buffers. A buffer is owned by the writer until every word in it has been written. It then passes to the reader, and once the reader has taken its last word it returns to the writer. Because buffers move as whole units, the writer can fill one buffer while the reader drains another, and neither side waits on a buffer the other is using.

Neither port sees buffer boundaries. The writer sees one ready signal that stays high while any buffer is free to fill. The reader sees one valid signal that is high while a completed buffer still holds words. Buffers are filled and drained in a fixed rotation, so words come out in exactly the order they went in. The buffer count and the buffer size are set by two configuration inputs. New settings are taken only while the whole pool is empty.

Top module: `pkt_buf_rotator`

## Requirements
- R1: After a synchronous reset, wr_ready is 1, wr_full is 0, rd_valid is 0 and rd_empty is 1, and every buffer is free for writing.
- R2: cfg_bufs selects the number of buffers: code 0 gives 2, code 1 gives 3, and codes 2 and 3 give 4. With no reads, the writer is accepted for exactly count × size words, and then wr_ready falls and wr_full rises.
- R3: cfg_large selects the words per buffer: 0 gives SMALL_WORDS and 1 gives LARGE_WORDS.
- R4: A partly written buffer is never visible to the reader. rd_valid stays 0 until a buffer is complete, and the first word of that buffer appears on the read port two clock edges after the edge that accepted the buffer's last word.
- R5: Words leave the read port in exactly the order they were accepted, across buffer boundaries and across wrap-around of the rotation.
- R6: When the last word of the oldest complete buffer moves into the read output register, that buffer returns to the writer. wr_ready rises again while other complete buffers are still waiting to be read.
- R7: When the reader is always ready, a writer that presents data on every cycle is never stalled, whatever the buffer count. One buffer fills while the previous one drains.
- R8: While rd_valid is 1 and rd_ready is 0, rd_valid and rd_data hold their values into the next cycle.
- R9: A change of cfg_bufs or cfg_large is ignored while any word is stored or in flight. It takes effect on the first cycle in which the pool is empty and no write is accepted, and the rotation then restarts at buffer 0.
- R10: wr_full is always the complement of wr_ready, and rd_empty is always the complement of rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_bufs | input | 2 | Buffer count code (0: two, 1: three, 2 or 3: four) |
| cfg_large | input | 1 | Buffer size select (0: SMALL_WORDS, 1: LARGE_WORDS) |
| wr_valid | input | 1 | Writer presents a word |
| wr_data | input | DATA_W | Word to store |
| wr_ready | output | 1 | A buffer has room; a word is taken when wr_valid is also high |
| wr_full | output | 1 | No buffer is available to the writer |
| rd_valid | output | 1 | rd_data holds a word from a completed buffer |
| rd_data | output | DATA_W | Oldest unread word |
| rd_ready | input | 1 | Reader takes the word on rd_data |
| rd_empty | output | 1 | No completed word is presented to the reader |

## Verification
On every cycle, the assertions check that the count of completed buffers never exceeds the configured buffer count. They also check that the writer stops right after the last free buffer fills, that a stalled read output stays frozen, and that an overlapping write completion and buffer release leave the writer running. Further properties check that the settings stay frozen while data is held, and that a newly completed buffer reaches the read port after exactly two edges. Byte-exact ordering across rotation wrap, the total capacity for each configuration code and size, a settings change made while data is stored, and release of a buffer back to the writer can only be shown by the bench's sweeps. In those sweeps, every combination of count and size is filled, drained with stalls and streamed against a reference queue.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

  localparam int MAX_BUFS = 4;

  typedef enum logic [1:0] {
    BUFS_TWO   = 2'd0,
    BUFS_THREE = 2'd1,
    BUFS_FOUR  = 2'd2,
    BUFS_FOUR2 = 2'd3
  } bufs_code_e;

  function automatic logic [2:0] buf_count(input logic [1:0] code);
    case (bufs_code_e'(code))
      BUFS_TWO:   buf_count = 3'd2;
      BUFS_THREE: buf_count = 3'd3;
      default:    buf_count = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/pbr_store.sv
module pbr_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram [0:DEPTH-1];

  // one write port, one registered read port: maps onto a simple dual-port RAM
  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= ram[raddr];
  end

endmodule

// File: rtl/pbr_cursor.sv
module pbr_cursor #(
  parameter int IDX_W = 2,
  parameter int OFF_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic [OFF_W-1:0] last_off,
  input  logic [IDX_W-1:0] last_idx,
  output logic [IDX_W-1:0] idx,
  output logic [OFF_W-1:0] off,
  output logic             at_end
);

  assign at_end = (off == last_off);

  // walks word by word through a buffer, then on to the next buffer in rotation
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx <= '0;
      off <= '0;
    end else if (step) begin
      if (at_end) begin
        off <= '0;
        idx <= (idx == last_idx) ? '0 : idx + 1'b1;
      end else begin
        off <= off + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pkt_buf_rotator.sv
module pkt_buf_rotator
  import pbr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SMALL_WORDS = 512,
  parameter int LARGE_WORDS = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_bufs,
  input  logic              cfg_large,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              wr_full,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rd_ready,
  output logic              rd_empty
);

  localparam int IDX_W  = $clog2(MAX_BUFS);
  localparam int OFF_W  = $clog2(LARGE_WORDS);
  localparam int ADDR_W = IDX_W + OFF_W;
  localparam int CNT_W  = $clog2(MAX_BUFS + 1);
  localparam logic [OFF_W-1:0] SMALL_M1 = OFF_W'(SMALL_WORDS - 1);
  localparam logic [OFF_W-1:0] LARGE_M1 = OFF_W'(LARGE_WORDS - 1);

  // active configuration
  logic [1:0]       cfg_code_q;
  logic             cfg_large_q;
  logic [CNT_W-1:0] nbuf_act;
  logic [OFF_W-1:0] last_off;
  logic [IDX_W-1:0] last_idx;

  // completed buffers whose words are not yet all fetched
  logic [CNT_W-1:0] cnt_full, cnt_nxt;
  logic             wr_ready_q, rd_valid_q;

  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [OFF_W-1:0] wr_off, rd_off;
  logic             wr_at_end, rd_at_end;

  logic wr_fire, wr_done, fetch, fetch_last, idle, cfg_diff, reload;

  assign nbuf_act = CNT_W'(buf_count(cfg_code_q));
  assign last_off = cfg_large_q ? LARGE_M1 : SMALL_M1;
  assign last_idx = IDX_W'(nbuf_act - 1'b1);

  assign wr_fire    = wr_valid & wr_ready_q;
  assign wr_done    = wr_fire & wr_at_end;
  assign fetch      = (cnt_full != '0) & (~rd_valid_q | rd_ready);
  assign fetch_last = fetch & rd_at_end;
  assign idle       = (cnt_full == '0) & (wr_off == '0) & ~rd_valid_q;
  assign cfg_diff   = (cfg_bufs != cfg_code_q) | (cfg_large != cfg_large_q);
  assign reload     = idle & cfg_diff & ~wr_fire;

  always_comb begin
    cnt_nxt = cnt_full;
    case ({wr_done, fetch_last})
      2'b10:   cnt_nxt = cnt_full + 1'b1;
      2'b01:   cnt_nxt = cnt_full - 1'b1;
      default: cnt_nxt = cnt_full;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_code_q  <= cfg_bufs;
      cfg_large_q <= cfg_large;
      cnt_full    <= '0;
      wr_ready_q  <= 1'b1;
      rd_valid_q  <= 1'b0;
    end else if (reload) begin
      cfg_code_q  <= cfg_bufs;
      cfg_large_q <= cfg_large;
      cnt_full    <= '0;
      wr_ready_q  <= 1'b1;
      rd_valid_q  <= 1'b0;
    end else begin
      cnt_full    <= cnt_nxt;
      wr_ready_q  <= (cnt_nxt != nbuf_act);
      rd_valid_q  <= fetch | (rd_valid_q & ~rd_ready);
    end
  end

  pbr_cursor #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_wr_cur (
    .clk(clk), .rst(rst), .clr(reload), .step(wr_fire),
    .last_off(last_off), .last_idx(last_idx),
    .idx(wr_idx), .off(wr_off), .at_end(wr_at_end)
  );

  pbr_cursor #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_rd_cur (
    .clk(clk), .rst(rst), .clr(reload), .step(fetch),
    .last_off(last_off), .last_idx(last_idx),
    .idx(rd_idx), .off(rd_off), .at_end(rd_at_end)
  );

  pbr_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk),
    .we(wr_fire), .waddr({wr_idx, wr_off}), .wdata(wr_data),
    .re(fetch),   .raddr({rd_idx, rd_off}), .rdata(rd_data)
  );

  assign wr_ready = wr_ready_q;
  assign wr_full  = ~wr_ready_q;
  assign rd_valid = rd_valid_q;
  assign rd_empty = ~rd_valid_q;

endmodule

// File: rtl/pkt_buf_rotator_chk.sv
module pkt_buf_rotator_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_fire,
  input logic              wr_at_end,
  input logic              fetch_last,
  input logic [CNT_W-1:0]  cnt_full,
  input logic [CNT_W-1:0]  nbuf_act,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              idle,
  input logic [1:0]        cfg_code_q,
  input logic              cfg_large_q
);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_full <= nbuf_act);

  assert_last_free_fills_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && wr_at_end && cnt_full == nbuf_act - 1'b1 && !fetch_last) |=> !wr_ready);

  assert_partial_hidden_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_full == '0 && !rd_valid) |=> !rd_valid);

  assert_handover_delay_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && wr_at_end && cnt_full == '0 && !rd_valid) |=> ##1 rd_valid);

  assert_overlap_no_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && wr_at_end && fetch_last) |=> wr_ready);

  assert_read_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_cfg_locked_R9: assert property (@(posedge clk) disable iff (rst)
    !idle |=> ($stable(cfg_code_q) && $stable(cfg_large_q)));

endmodule

bind pkt_buf_rotator pkt_buf_rotator_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_fire(wr_fire), .wr_at_end(wr_at_end),
  .fetch_last(fetch_last), .cnt_full(cnt_full), .nbuf_act(nbuf_act),
  .wr_ready(wr_ready_q), .rd_valid(rd_valid_q), .rd_ready(rd_ready),
  .rd_data(rd_data), .idle(idle), .cfg_code_q(cfg_code_q), .cfg_large_q(cfg_large_q)
);

// File: tb/sim_pkt_buf_rotator.sv
module sim_pkt_buf_rotator;

  localparam int SW = 4;
  localparam int LW = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_bufs = 2'd0;
  logic       cfg_large = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       wr_ready, wr_full, rd_valid, rd_empty;
  logic [7:0] rd_data;
  logic       rd_ready = 1'b0;

  always #10 clk = ~clk;

  pkt_buf_rotator #(.DATA_W(8), .SMALL_WORDS(SW), .LARGE_WORDS(LW)) u0 (
    .clk(clk), .rst(rst), .cfg_bufs(cfg_bufs), .cfg_large(cfg_large),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready), .wr_full(wr_full),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready), .rd_empty(rd_empty)
  );

  int n_chk = 0, n_fail = 0;
  int seq = 0;
  logic [7:0] q[$];
  int run_wr, run_rd, flag_bad, hold_bad, order_bad, wr_block, stall_seen, regain;
  bit stall_pend = 0;
  logic [7:0] stall_data;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  function automatic int nbuf_of(input int code);
    return (code == 0) ? 2 : (code == 1) ? 3 : 4;
  endfunction

  task automatic clear_stats();
    flag_bad = 0; hold_bad = 0; order_bad = 0; wr_block = 0; stall_seen = 0; regain = 0;
  endtask

  // rmode: 0 never ready, 1 always ready, 2 ready two cycles of every three
  task automatic run(input int n, input bit wv, input int rmode);
    run_wr = 0; run_rd = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wr_valid = wv;
      wr_data  = seq[7:0];
      rd_ready = (rmode == 1) || (rmode == 2 && (k % 3) != 0);
      if (wr_full !== !wr_ready || rd_empty !== !rd_valid) flag_bad++;
      if (stall_pend) begin
        if (!(rd_valid && rd_data == stall_data)) hold_bad++;
        stall_pend = 0;
      end
      if (wv && !wr_ready) wr_block++;
      if (wv && wr_ready) begin
        q.push_back(seq[7:0]);
        seq++;
        run_wr++;
      end
      if (rd_valid && rd_ready) begin
        if (q.size() == 0) order_bad++;
        else if (q.pop_front() != rd_data) order_bad++;
        run_rd++;
      end else if (rd_valid) begin
        stall_pend = 1;
        stall_data = rd_data;
        stall_seen++;
      end
      if (rmode != 0 && wr_ready && q.size() > 0) regain++;
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wr_valid = 1'b0;
      rd_ready = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(wr_ready == 1'b1 && wr_full == 1'b0, "R1", "writer free after reset", wr_ready, 1);
    chk(rd_valid == 1'b0 && rd_empty == 1'b1, "R1", "reader empty after reset", rd_valid, 0);

    for (int code = 0; code < 4; code++) begin
      for (int lg = 0; lg < 2; lg++) begin
        int nb, sz;
        nb = nbuf_of(code);
        sz = (lg == 1) ? LW : SW;
        @(negedge clk);
        cfg_bufs = 2'(code);
        cfg_large = lg[0];
        idle_cycles(3);
        clear_stats();

        // partial buffer stays hidden (R4)
        run(sz - 1, 1'b1, 0);
        idle_cycles(3);
        chk(rd_valid == 1'b0, "R4", "partial buffer hidden", rd_valid, 0);
        run(1, 1'b1, 0);
        @(negedge clk);
        wr_valid = 1'b0;
        chk(rd_valid == 1'b0, "R4", "one edge after completion", rd_valid, 0);
        @(negedge clk);
        chk(rd_valid == 1'b1, "R4", "two edges after completion", rd_valid, 1);

        // fill the rest of the pool (R2, R3)
        run(nb * sz + 5, 1'b1, 0);
        chk(run_wr == (nb - 1) * sz, "R2", "remaining capacity", run_wr, (nb - 1) * sz);
        chk(q.size() == nb * sz, "R3", "total words stored", q.size(), nb * sz);
        idle_cycles(1);
        chk(wr_full == 1'b1 && wr_ready == 1'b0, "R2", "writer blocked when pool full", wr_full, 1);

        // drain with stalls (R5, R6, R8)
        run(3 * nb * sz + 10, 1'b0, 2);
        chk(order_bad == 0, "R5", "read order", order_bad, 0);
        chk(q.size() == 0, "R5", "all words read", q.size(), 0);
        chk(hold_bad == 0 && stall_seen > 0, "R8", "stalled output held", hold_bad, 0);
        chk(regain > 0, "R6", "writer regains buffer while reads pending", regain > 0, 1);
        idle_cycles(1);
        chk(wr_ready == 1'b1 && rd_empty == 1'b1, "R6", "pool free after drain", wr_ready, 1);

        // concurrent streaming (R7)
        clear_stats();
        run(3 * nb * sz, 1'b1, 1);
        chk(wr_block == 0, "R7", "writer never stalled", wr_block, 0);
        run(nb * sz + 10, 1'b0, 1);
        chk(order_bad == 0 && q.size() == 0, "R5", "streamed order", order_bad, 0);
        chk(flag_bad == 0, "R10", "flags complement handshakes", flag_bad, 0);
      end
    end

    // configuration change while data held (R9)
    @(negedge clk);
    cfg_bufs = 2'd0;
    cfg_large = 1'b0;
    idle_cycles(3);
    clear_stats();
    run(1, 1'b1, 0);
    @(negedge clk);
    wr_valid = 1'b0;
    cfg_bufs = 2'd2;
    cfg_large = 1'b1;
    idle_cycles(2);
    run(20, 1'b1, 0);
    chk(run_wr == 2 * SW - 1, "R9", "old setting kept while busy", run_wr, 2 * SW - 1);
    run(40, 1'b0, 1);
    chk(q.size() == 0 && order_bad == 0, "R9", "drain before new setting", q.size(), 0);
    idle_cycles(3);
    run(4 * LW + 8, 1'b1, 0);
    chk(run_wr == 4 * LW, "R9", "new setting applied when empty", run_wr, 4 * LW);
    run(8 * LW + 10, 1'b0, 1);
    chk(q.size() == 0 && order_bad == 0, "R5", "order after reconfiguration", order_bad, 0);

    // reset with data stored (R1)
    run(5, 1'b1, 0);
    @(negedge clk);
    wr_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    q.delete();
    stall_pend = 0;
    @(negedge clk);
    chk(wr_ready == 1'b1 && rd_valid == 1'b0, "R1", "reset clears stored data", rd_valid, 0);
    chk(wr_full == 1'b0 && rd_empty == 1'b1, "R1", "flags after reset", rd_empty, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule